// File: doc/BRIEF.md
# Subchannel Engine Binding Router

The router takes a stream of register writes, each made of a method number, a subchannel number and a 32-bit value, and delivers the writes that are meant for an engine to one of three engine ports. Which engine a subchannel reaches is not fixed in hardware. It is set at run time by an in-band bind command. A write to method 0 stores the low 16 bits of its value as the engine class of that subchannel. Later engine-level writes on that subchannel go to the port that serves that class.

Methods 1 to 0xFF belong to the command buffer itself. They are absorbed and are never forwarded. Four sticky status bits report faults. A dropped write never reaches a port. The three engine ports share one method bus and one value bus. Each port has its own valid and ready pins.

The input is a valid/ready stream. A write is accepted on a clock edge where `in_valid` and `in_ready` are both high. When a write is headed for an engine port, `in_ready` follows that port's ready and the matching valid stays asserted. This holds the write at the input until the engine takes it. Writes that are not forwarded are accepted at once. Each accepted write reaches at most one port, so each port sees at most one write per cycle.

Top module: `subch_router`

## Requirements
- R1: After reset every subchannel is unbound, all four status bits read 0 and no engine valid is asserted.
- R2: An accepted write to method 0 on an unbound subchannel binds that subchannel to the class in value[15:0]. It is forwarded to no port and changes no status bit.
- R3: A write with method >= 0x100 on a bound subchannel whose class has a port raises exactly that port's valid. The shared method and value buses carry the write's method and value unchanged.
- R4: The ports are indexed in the valid and ready vectors as follows: class 0x902D maps to index 0 (2D), class 0xB197 to index 1 (3D) and class 0xB1C0 to index 2 (compute).
- R5: A write with method 1..0xFF is accepted at once and forwarded nowhere. It sets `err_bufm`.
- R6: An engine write on a subchannel bound to a class with no port is dropped and sets `err_class`. This covers 0xA140, 0xB0B5 and any other unrecognised class.
- R7: A bind on a subchannel that is already bound is dropped and sets `err_rebind`. The existing binding stays in force.
- R8: An engine write on an unbound subchannel is dropped and sets `err_unbound`.
- R9: For a write that is forwarded, `in_ready` equals the target port's ready, and the port valid stays high while that ready is low. A stalled port does not hold back writes aimed at other ports. For writes that are not forwarded, `in_ready` is 1.
- R10: A status bit goes high on the clock edge that accepts the offending write. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input write present |
| in_ready | output | 1 | Input write accepted this cycle when high with in_valid |
| in_method | input | 13 | Method number of the write |
| in_subch | input | 3 | Subchannel of the write |
| in_value | input | 32 | Data of the write |
| eng_valid | output | 3 | Per-port valid (0 = 2D, 1 = 3D, 2 = compute) |
| eng_ready | input | 3 | Per-port ready |
| eng_method | output | 13 | Method shared by all ports |
| eng_value | output | 32 | Value shared by all ports |
| err_rebind | output | 1 | Sticky: bind of an already bound subchannel |
| err_unbound | output | 1 | Sticky: engine write to an unbound subchannel |
| err_class | output | 1 | Sticky: engine write to a class with no port |
| err_bufm | output | 1 | Sticky: buffer-level method other than bind |

## Verification
Some properties are checked by assertions on every cycle:
- No more than one port valid is ever high.
- Buffer-level methods never produce a port valid.
- A forwarded write is held with in_ready low while its port refuses it.
- The status bits never fall outside reset.

The class-to-port mapping, the effect of a bind on later traffic, the survival of the first binding after a refused rebind, and which status bit each fault raises all depend on the history held in the binding table. Only the bench's scenarios show these, against its own model of the table.

// File: rtl/subch_router_pkg.sv
package subch_router_pkg;
  localparam int CLASS_W   = 16;
  localparam int NUM_PORTS = 3;

  localparam logic [CLASS_W-1:0] CLS_2D  = 16'h902D;
  localparam logic [CLASS_W-1:0] CLS_3D  = 16'hB197;
  localparam logic [CLASS_W-1:0] CLS_CMP = 16'hB1C0;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_2D     = 3'd1,
    TGT_3D     = 3'd2,
    TGT_CMP    = 3'd3,
    TGT_NOPORT = 3'd4
  } tgt_e;

  function automatic tgt_e class_to_tgt(input logic [CLASS_W-1:0] cls);
    case (cls)
      CLS_2D:  class_to_tgt = TGT_2D;
      CLS_3D:  class_to_tgt = TGT_3D;
      CLS_CMP: class_to_tgt = TGT_CMP;
      default: class_to_tgt = TGT_NOPORT;
    endcase
  endfunction
endpackage

// File: rtl/subch_bind_table.sv
module subch_bind_table
  import subch_router_pkg::*;
#(
  parameter int NUM_SUBCH = 8,
  localparam int SW = $clog2(NUM_SUBCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_idx,
  input  tgt_e          wr_tgt,
  input  logic [SW-1:0] rd_idx,
  output tgt_e          rd_tgt
);
  tgt_e entry_q [NUM_SUBCH];

  for (genvar g = 0; g < NUM_SUBCH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) entry_q[g] <= TGT_NONE;
      else if (wr_en && wr_idx == SW'(g)) entry_q[g] <= wr_tgt;
    end
  end

  assign rd_tgt = entry_q[rd_idx];
endmodule

// File: rtl/subch_decode.sv
module subch_decode
  import subch_router_pkg::*;
#(
  parameter int METHOD_W  = 13,
  parameter int BUF_LIMIT = 'h100
) (
  input  logic [METHOD_W-1:0]  method,
  input  tgt_e                 tgt,
  output logic                 is_bind,
  output logic                 is_buf,
  output logic                 is_eng,
  output logic [NUM_PORTS-1:0] port_sel
);
  always_comb begin
    is_bind  = (method == '0);
    is_buf   = !is_bind && (method < METHOD_W'(BUF_LIMIT));
    is_eng   = !is_bind && !is_buf;
    port_sel = '0;
    if (is_eng) begin
      case (tgt)
        TGT_2D:  port_sel[0] = 1'b1;
        TGT_3D:  port_sel[1] = 1'b1;
        TGT_CMP: port_sel[2] = 1'b1;
        default: port_sel = '0;
      endcase
    end
  end
endmodule

// File: rtl/subch_status.sv
module subch_status #(
  parameter int NUM_ERR = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ERR-1:0] set,
  output logic [NUM_ERR-1:0] flags
);
  for (genvar g = 0; g < NUM_ERR; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags[g] <= 1'b0;
      else if (set[g]) flags[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/subch_router.sv
module subch_router
  import subch_router_pkg::*;
#(
  parameter int NUM_SUBCH = 8,
  parameter int METHOD_W  = 13,
  parameter int DATA_W    = 32,
  parameter int BUF_LIMIT = 'h100,
  localparam int SW = $clog2(NUM_SUBCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [METHOD_W-1:0]  in_method,
  input  logic [SW-1:0]        in_subch,
  input  logic [DATA_W-1:0]    in_value,
  output logic [NUM_PORTS-1:0] eng_valid,
  input  logic [NUM_PORTS-1:0] eng_ready,
  output logic [METHOD_W-1:0]  eng_method,
  output logic [DATA_W-1:0]    eng_value,
  output logic                 err_rebind,
  output logic                 err_unbound,
  output logic                 err_class,
  output logic                 err_bufm
);
  localparam int NUM_ERR = 4;

  tgt_e                 cur_tgt;
  logic                 is_bind, is_buf, is_eng, accept, bind_we;
  logic [NUM_PORTS-1:0] port_sel;
  logic [NUM_ERR-1:0]   err_set, err_flags;

  subch_bind_table #(.NUM_SUBCH(NUM_SUBCH)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bind_we),
    .wr_idx (in_subch),
    .wr_tgt (class_to_tgt(in_value[CLASS_W-1:0])),
    .rd_idx (in_subch),
    .rd_tgt (cur_tgt)
  );

  subch_decode #(.METHOD_W(METHOD_W), .BUF_LIMIT(BUF_LIMIT)) u_dec (
    .method   (in_method),
    .tgt      (cur_tgt),
    .is_bind  (is_bind),
    .is_buf   (is_buf),
    .is_eng   (is_eng),
    .port_sel (port_sel)
  );

  assign eng_valid  = {NUM_PORTS{in_valid}} & port_sel;
  assign eng_method = in_method;
  assign eng_value  = in_value;
  assign in_ready   = (|port_sel) ? |(port_sel & eng_ready) : 1'b1;
  assign accept     = in_valid && in_ready;
  assign bind_we    = accept && is_bind && (cur_tgt == TGT_NONE);

  assign err_set[0] = accept && is_bind && (cur_tgt != TGT_NONE);
  assign err_set[1] = accept && is_eng  && (cur_tgt == TGT_NONE);
  assign err_set[2] = accept && is_eng  && (cur_tgt == TGT_NOPORT);
  assign err_set[3] = accept && is_buf;

  subch_status #(.NUM_ERR(NUM_ERR)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (err_set),
    .flags (err_flags)
  );

  assign err_rebind  = err_flags[0];
  assign err_unbound = err_flags[1];
  assign err_class   = err_flags[2];
  assign err_bufm    = err_flags[3];
endmodule

// File: rtl/subch_router_chk.sv
module subch_router_chk #(
  parameter int METHOD_W  = 13,
  parameter int BUF_LIMIT = 'h100
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [METHOD_W-1:0] in_method,
  input logic [2:0]          eng_valid,
  input logic [2:0]          eng_ready,
  input logic                err_rebind,
  input logic                err_unbound,
  input logic                err_class,
  input logic                err_bufm
);
  p_one_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_valid));

  p_buf_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_method != '0 && in_method < METHOD_W'(BUF_LIMIT)) |-> (eng_valid == '0 && in_ready));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(eng_valid & ~eng_ready)) |-> !in_ready);

  p_ready_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_valid) |-> (in_ready == |(eng_valid & eng_ready)));

  p_sticky_rebind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_rebind |=> err_rebind);
  p_sticky_unbound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_unbound |=> err_unbound);
  p_sticky_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_class |=> err_class);
  p_sticky_bufm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_bufm |=> err_bufm);
endmodule

bind subch_router subch_router_chk #(.METHOD_W(METHOD_W), .BUF_LIMIT(BUF_LIMIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_method   (in_method),
  .eng_valid   (eng_valid),
  .eng_ready   (eng_ready),
  .err_rebind  (err_rebind),
  .err_unbound (err_unbound),
  .err_class   (err_class),
  .err_bufm    (err_bufm)
);

// File: tb/tb_subch_router.sv
module tb_subch_router;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [12:0] in_method;
  logic [2:0]  in_subch;
  logic [31:0] in_value;
  logic [2:0]  eng_valid;
  logic [2:0]  eng_ready;
  logic [12:0] eng_method;
  logic [31:0] eng_value;
  logic        err_rebind, err_unbound, err_class, err_bufm;

  int checks = 0;
  int failures = 0;

  logic        m_bound [8];
  logic [15:0] m_cls   [8];
  logic [3:0]  m_err;

  always #2 clk = ~clk;

  subch_router dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_method(in_method), .in_subch(in_subch), .in_value(in_value),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_method(eng_method),
    .eng_value(eng_value), .err_rebind(err_rebind), .err_unbound(err_unbound),
    .err_class(err_class), .err_bufm(err_bufm)
  );

  function automatic logic [2:0] port_of(input logic [15:0] cls);
    case (cls)
      16'h902D: port_of = 3'b001;
      16'hB197: port_of = 3'b010;
      16'hB1C0: port_of = 3'b100;
      default:  port_of = 3'b000;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin m_bound[i] = 1'b0; m_cls[i] = 16'h0; end
    m_err = 4'b0;
    check("R1 status after reset", {err_bufm, err_class, err_unbound, err_rebind}, 4'b0);
    check("R1 no valid after reset", eng_valid, 3'b0);
  endtask

  // One write with all ports ready; predicts routing and status from the model.
  task automatic op(input string req, input logic [12:0] m, input logic [2:0] s, input logic [31:0] v);
    logic [2:0] exp_v;
    @(negedge clk);
    in_valid = 1'b1; in_method = m; in_subch = s; in_value = v;
    exp_v = (m >= 13'h100 && m_bound[s]) ? port_of(m_cls[s]) : 3'b000;
    #1;
    check({req, " port valid"}, eng_valid, exp_v);
    check({req, " in_ready"}, in_ready, 1'b1);
    if (exp_v != 0) begin
      check({req, " method"}, eng_method, m);
      check({req, " value"}, eng_value, v);
    end
    if (m == 0) begin
      if (m_bound[s]) m_err[0] = 1'b1;
      else begin m_bound[s] = 1'b1; m_cls[s] = v[15:0]; end
    end else if (m < 13'h100) m_err[3] = 1'b1;
    else if (!m_bound[s]) m_err[1] = 1'b1;
    else if (port_of(m_cls[s]) == 0) m_err[2] = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    check({req, " status"}, {err_bufm, err_class, err_unbound, err_rebind}, m_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] cls_list [8];
    logic [12:0] meths [3];
    cls_list = '{16'h902D, 16'hB197, 16'hB1C0, 16'hA140, 16'hB0B5, 16'h1234, 16'h902D, 16'hB197};
    meths = '{13'h100, 13'h1FFF, 13'h155};
    rst_n = 1'b0; in_valid = 1'b0; in_method = '0; in_subch = '0; in_value = '0;
    eng_ready = 3'b111;
    do_reset();

    // R1/R8: every subchannel starts unbound
    for (int s = 0; s < 8; s++) op("R8 unbound write", 13'h200, 3'(s), 32'hA5A5_0000 + s);
    do_reset();

    // R2: bind all subchannels
    for (int s = 0; s < 8; s++) op("R2 bind", 13'h0, 3'(s), {16'hFFFF, cls_list[s]});

    // R3/R4/R6: sweep subchannels and methods
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 3; k++)
        op("R3 R4 R6 route", meths[k], 3'(s), 32'h1000_0000 * k + 32'h0101 * s);

    // R7: rebind keeps the first binding
    op("R7 rebind", 13'h0, 3'd0, 32'h0000_B197);
    op("R7 old binding kept", 13'h300, 3'd0, 32'hDEAD_BEEF);

    // R5: buffer-level methods absorbed
    op("R5 buffer method low", 13'h001, 3'd1, 32'h1);
    op("R5 buffer method high", 13'h0FF, 3'd2, 32'h2);

    // R10: flags persist over clean traffic
    op("R10 sticky", 13'h400, 3'd1, 32'h77);

    // R1: reset clears bindings
    do_reset();
    op("R1 cleared binding", 13'h100, 3'd0, 32'h5);

    // R9: back-pressure
    do_reset();
    op("R9 bind 3D", 13'h0, 3'd2, 32'hB197);
    op("R9 bind 2D", 13'h0, 3'd3, 32'h902D);
    eng_ready = 3'b101;
    @(negedge clk);
    in_valid = 1'b1; in_method = 13'h123; in_subch = 3'd2; in_value = 32'hCAFE;
    for (int c = 0; c < 3; c++) begin
      #1;
      check("R9 stalled in_ready", in_ready, 1'b0);
      check("R9 valid held", eng_valid, 3'b010);
      @(negedge clk);
    end
    in_subch = 3'd3; #1;
    check("R9 other port not blocked valid", eng_valid, 3'b001);
    check("R9 other port not blocked ready", in_ready, 1'b1);
    in_subch = 3'd2;
    eng_ready = 3'b111; #1;
    check("R9 released in_ready", in_ready, 1'b1);
    @(posedge clk); #1;
    in_valid = 1'b0; #1;
    check("R9 no valid after accept", eng_valid, 3'b0);
    check("R9 no status", {err_bufm, err_class, err_unbound, err_rebind}, 4'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule